// File: doc/BRIEF.md
# Exclusive Dual-Core Switch Sequencer

This block hands execution over between two cores that run the same instruction set: a fast core and a slow, low-power core. Only one of them runs at any time. A switch request names the core that should run next. If that core is not the one running, the sequencer stops the running core and moves its architectural state to the other core. The special-purpose register file is copied whole over a wide parallel bus that holds the data for one cycle. General-purpose and control registers are pushed one per cycle into a local scratchpad stack and then popped into the new core. The new core's leftover state is cleared with a flush strobe, and then its run enable is raised.

The cores are modelled at the sequencer's edge. Each core has a run enable and a clock enable. A shared read index with one read-data input per core serves the source side, and a shared write index and data with one write enable per core serves the target side. Each core also has a special-purpose vector input, a load strobe and a flush strobe. Indices 0 and 1 of every per-core pair stand for the fast core and the slow core.

Top module: `core_switch_seq`

## Requirements
- R1: After reset, the sequencer is idle with `busy` and `done` low, no strobes active, and the core selected by `RESET_CORE` (0 = fast) holding both its run enable and its clock enable.
- R2: At most one bit of `core_run` is high at any time, and exactly one bit of `clk_en` is high at any time. When idle, the run enable and the clock enable select the same core.
- R3: During a switch, `spr_ld` pulses for exactly one cycle, and only for the target core. While that pulse is high, `spr_bus` carries the source core's special-purpose vector.
- R4: The stack saves the source registers in ascending index order, one per cycle, starting at index 0. `rf_rd_idx` rises by one on each cycle of the save phase.
- R5: After a switch, register i of the target core holds the value that register i of the source core held, for every i below `NSTK`. Exactly `NSTK` writes reach the target core, in ascending order, and none reach the source core.
- R6: Each switch that changes cores produces exactly one `flush` pulse, on the target core, in the cycle after the last restore write.
- R7: `done` is a one-cycle pulse. In that cycle the target core's run enable is already high.
- R8: A request that names the core already running raises `done` on the next cycle. It causes no register write, no special-purpose load and no flush.
- R9: A request that arrives while `busy` is high is ignored. The core that runs afterwards, and the state that was moved, are those of the accepted request.
- R10: A switch that changes cores keeps `busy` high for 2·`NSTK`+5 cycles (61 with the defaults). A request that names the running core keeps `busy` high for exactly 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_req | input | 1 | Switch request, sampled only while idle |
| sw_tgt | input | 1 | Requested core: 0 fast, 1 slow |
| busy | output | 1 | High from the accepted request until the cycle of `done` |
| done | output | 1 | One-cycle completion pulse |
| core_run | output | 2 | Run enables per core |
| clk_en | output | 2 | Clock enables per core |
| rf_rd_idx | output | IW | Register index read from the source core during the save phase |
| rf_rd_data_fast | input | W | Fast core register read data |
| rf_rd_data_slow | input | W | Slow core register read data |
| rf_wr_idx | output | IW | Register index written during the restore phase |
| rf_wr_data | output | W | Restore write data |
| rf_wr_en | output | 2 | Restore write enables per core |
| spr_fast | input | NSPR·W | Fast core special-purpose register vector |
| spr_slow | input | NSPR·W | Slow core special-purpose register vector |
| spr_bus | output | NSPR·W | Dedicated special-purpose transfer bus |
| spr_ld | output | 2 | Special-purpose load strobes per core |
| flush | output | 2 | Flush strobes per core |

## Verification
Two events can fall in the same cycle: the completion pulse and a new request. A request that arrives while `done` is high must be dropped, because the sequencer is still busy. The bench forces this by raising a request for the opposite core at chosen cycles inside a switch, including the `done` cycle itself. It then checks that `busy` stays low afterwards, that the running core is the accepted target, and that no extra write, load or flush appears. Random switch targets cover both the change-core sequence and the same-core case. Each switch uses fresh random register contents.

// File: rtl/csw_pkg.sv
package csw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HALT  = 3'd1,
      ST_XSPR  = 3'd2,
      ST_PUSH  = 3'd3,
      ST_SWAP  = 3'd4,
      ST_POP   = 3'd5,
      ST_FLUSH = 3'd6,
      ST_RUN   = 3'd7
   } csw_state_t;
endpackage

// File: rtl/csw_ctrl.sv
module csw_ctrl
   import csw_pkg::*;
#(
   parameter int NSTK       = 28,
   parameter bit RESET_CORE = 1'b0,
   localparam int CW        = $clog2(NSTK + 1)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_req,
   input  logic            sw_tgt,
   output csw_state_t      state,
   output logic [CW-1:0]   cnt,
   output logic            active,
   output logic            tgt
);
   localparam logic [CW-1:0] LAST = CW'(NSTK - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         active <= RESET_CORE;
         tgt    <= RESET_CORE;
      end else begin
         unique case (state)
            ST_IDLE: if (sw_req) begin
               tgt   <= sw_tgt;
               state <= (sw_tgt == active) ? ST_RUN : ST_HALT;
            end
            ST_HALT: state <= ST_XSPR;
            ST_XSPR: begin
               cnt   <= '0;
               state <= ST_PUSH;
            end
            ST_PUSH: if (cnt == LAST) begin
               cnt   <= '0;
               state <= ST_SWAP;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_SWAP: begin
               active <= tgt;
               state  <= ST_POP;
            end
            ST_POP: if (cnt == LAST) begin
               cnt   <= '0;
               state <= ST_FLUSH;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_FLUSH: state <= ST_RUN;
            ST_RUN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/csw_stack.sv
module csw_stack #(
   parameter int W    = 32,
   parameter int NSTK = 28,
   localparam int IW  = (NSTK > 1) ? $clog2(NSTK) : 1
)(
   input  logic          clk,
   input  logic          push_en,
   input  logic [IW-1:0] push_idx,
   input  logic [W-1:0]  push_data,
   input  logic [IW-1:0] pop_idx,
   output logic [W-1:0]  pop_data
);
   logic [W-1:0] mem [NSTK];

   always_ff @(posedge clk) begin
      if (push_en) mem[push_idx] <= push_data;
   end

   assign pop_data = mem[pop_idx];
endmodule

// File: rtl/csw_spr_link.sv
module csw_spr_link #(
   parameter int BW        = 1024,
   parameter int SPR_DELAY = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer,
   input  logic [BW-1:0] src_vec,
   output logic [BW-1:0] bus,
   output logic          ld
);
   generate
      if (SPR_DELAY == 1) begin : g_reg
         logic [BW-1:0] bus_q;
         logic          ld_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bus_q <= '0;
               ld_q  <= 1'b0;
            end else begin
               ld_q <= xfer;
               if (xfer) bus_q <= src_vec;
            end
         end
         assign bus = bus_q;
         assign ld  = ld_q;
      end else begin : g_comb
         assign bus = src_vec;
         assign ld  = xfer;
      end
   endgenerate
endmodule

// File: rtl/core_switch_seq.sv
module core_switch_seq
   import csw_pkg::*;
#(
   parameter int W          = 32,
   parameter int NSPR       = 32,
   parameter int NGPR       = 15,
   parameter int NCTL       = 13,
   parameter bit RESET_CORE = 1'b0,
   parameter int SPR_DELAY  = 1,
   localparam int NSTK      = NGPR + NCTL,
   localparam int IW        = (NSTK > 1) ? $clog2(NSTK) : 1,
   localparam int BW        = NSPR * W,
   localparam int CW        = $clog2(NSTK + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_req,
   input  logic          sw_tgt,
   output logic          busy,
   output logic          done,
   output logic [1:0]    core_run,
   output logic [1:0]    clk_en,
   output logic [IW-1:0] rf_rd_idx,
   input  logic [W-1:0]  rf_rd_data_fast,
   input  logic [W-1:0]  rf_rd_data_slow,
   output logic [IW-1:0] rf_wr_idx,
   output logic [W-1:0]  rf_wr_data,
   output logic [1:0]    rf_wr_en,
   input  logic [BW-1:0] spr_fast,
   input  logic [BW-1:0] spr_slow,
   output logic [BW-1:0] spr_bus,
   output logic [1:0]    spr_ld,
   output logic [1:0]    flush
);
   initial begin
      if (W < 1 || NSPR < 1 || NSTK < 1)
         $error("core_switch_seq: widths and counts must be positive");
      if (SPR_DELAY != 0 && SPR_DELAY != 1)
         $error("core_switch_seq: SPR_DELAY must be 0 or 1");
   end

   csw_state_t    state;
   logic [CW-1:0] cnt;
   logic          active;
   logic          tgt;
   logic          spr_ld_raw;
   logic [W-1:0]  src_rd;

   csw_ctrl #(.NSTK(NSTK), .RESET_CORE(RESET_CORE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_tgt(sw_tgt),
      .state(state), .cnt(cnt), .active(active), .tgt(tgt)
   );

   assign src_rd    = active ? rf_rd_data_slow : rf_rd_data_fast;
   assign rf_rd_idx = (state == ST_PUSH) ? IW'(cnt) : '0;
   assign rf_wr_idx = (state == ST_POP)  ? IW'(cnt) : '0;

   csw_stack #(.W(W), .NSTK(NSTK)) u_stack (
      .clk(clk),
      .push_en(state == ST_PUSH),
      .push_idx(rf_rd_idx),
      .push_data(src_rd),
      .pop_idx(rf_wr_idx),
      .pop_data(rf_wr_data)
   );

   csw_spr_link #(.BW(BW), .SPR_DELAY(SPR_DELAY)) u_spr (
      .clk(clk), .rst_n(rst_n),
      .xfer(state == ST_XSPR),
      .src_vec(active ? spr_slow : spr_fast),
      .bus(spr_bus),
      .ld(spr_ld_raw)
   );

   always_comb begin
      for (int k = 0; k < 2; k++) begin
         clk_en[k]   = (active == k[0]);
         core_run[k] = (active == k[0]) && (state == ST_IDLE || state == ST_RUN);
         rf_wr_en[k] = (tgt == k[0]) && (state == ST_POP);
         flush[k]    = (tgt == k[0]) && (state == ST_FLUSH);
         spr_ld[k]   = (tgt == k[0]) && spr_ld_raw;
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_RUN);
endmodule

// File: rtl/csw_checker.sv
module csw_checker #(
   parameter int IW = 5
)(
   input logic          clk,
   input logic          rst_n,
   input logic          sw_req,
   input logic          sw_tgt,
   input logic          busy,
   input logic          done,
   input logic [1:0]    core_run,
   input logic [1:0]    clk_en,
   input logic [IW-1:0] rf_rd_idx,
   input logic [1:0]    rf_wr_en,
   input logic [1:0]    spr_ld,
   input logic [1:0]    flush,
   input logic [2:0]    state
);
   localparam logic [2:0] S_PUSH = 3'd3;

   a_r2_run_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(core_run));
   a_r2_clk_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(clk_en));
   a_r2_idle_match: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> core_run == clk_en);
   a_r3_spr_single: assert property (@(posedge clk) disable iff (!rst_n)
      (spr_ld != 2'b00) |-> $onehot(spr_ld) && $past(spr_ld) == 2'b00);
   a_r4_push_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PUSH && $past(state) == S_PUSH) |-> rf_rd_idx == $past(rf_rd_idx) + 1'b1);
   a_r6_flush_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (flush != 2'b00) |-> $past(rf_wr_en) == flush);
   a_r7_done_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (core_run != 2'b00) ##1 !done);
   a_r8_same_core: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sw_req && clk_en[sw_tgt]) |=> done && rf_wr_en == 2'b00);
   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   a_r10_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));
endmodule

bind core_switch_seq csw_checker #(.IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_tgt(sw_tgt),
   .busy(busy), .done(done), .core_run(core_run), .clk_en(clk_en),
   .rf_rd_idx(rf_rd_idx), .rf_wr_en(rf_wr_en), .spr_ld(spr_ld),
   .flush(flush), .state(state)
);

// File: tb/core_switch_seq_tb.sv
module core_switch_seq_tb;
   localparam int W    = 32;
   localparam int NSPR = 32;
   localparam int NSTK = 28;
   localparam int IW   = 5;
   localparam int BW   = NSPR * W;
   localparam int SWITCH_BUSY = 2 * NSTK + 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_req = 1'b0, sw_tgt = 1'b0;
   logic busy, done;
   logic [1:0] core_run, clk_en, rf_wr_en, spr_ld, flush;
   logic [IW-1:0] rf_rd_idx, rf_wr_idx;
   logic [W-1:0] rf_wr_data;
   logic [BW-1:0] spr_bus;
   logic [BW-1:0] spr_src [2];
   logic [BW-1:0] spr_seen [2];
   logic [W-1:0]  rf [2][NSTK];
   int wr_cnt [2], ld_cnt [2], fl_cnt [2];
   int checks = 0, errors = 0;
   bit cur_core = 1'b0;

   always #2.5 clk = ~clk;

   core_switch_seq u_dut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_tgt(sw_tgt),
      .busy(busy), .done(done), .core_run(core_run), .clk_en(clk_en),
      .rf_rd_idx(rf_rd_idx),
      .rf_rd_data_fast(rf[0][rf_rd_idx < NSTK ? rf_rd_idx : 0]),
      .rf_rd_data_slow(rf[1][rf_rd_idx < NSTK ? rf_rd_idx : 0]),
      .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .rf_wr_en(rf_wr_en),
      .spr_fast(spr_src[0]), .spr_slow(spr_src[1]), .spr_bus(spr_bus),
      .spr_ld(spr_ld), .flush(flush)
   );

   always @(posedge clk) begin
      for (int k = 0; k < 2; k++) begin
         if (rf_wr_en[k]) begin
            rf[k][rf_wr_idx] <= rf_wr_data;
            wr_cnt[k] <= wr_cnt[k] + 1;
         end
         if (spr_ld[k]) begin
            spr_seen[k] <= spr_bus;
            ld_cnt[k] <= ld_cnt[k] + 1;
         end
         if (flush[k]) fl_cnt[k] <= fl_cnt[k] + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] rand_vec();
      logic [BW-1:0] v;
      for (int i = 0; i < NSPR; i++) v[i*W +: W] = $urandom;
      return v;
   endfunction

   function automatic logic [1:0] onehot_of(input bit c);
      return c ? 2'b10 : 2'b01;
   endfunction

   task automatic do_switch(input bit tgt, input int inject_at);
      logic [W-1:0] snap_src [NSTK];
      logic [W-1:0] snap_tgt [NSTK];
      logic [BW-1:0] exp_spr;
      int w0 [2], l0 [2], f0 [2];
      int bcyc = 0;
      bit src = cur_core;
      bit same = (tgt == src);
      bit mism = 0;
      for (int i = 0; i < NSTK; i++) begin
         rf[0][i] = $urandom; rf[1][i] = $urandom;
      end
      spr_src[0] = rand_vec(); spr_src[1] = rand_vec();
      for (int i = 0; i < NSTK; i++) begin
         snap_src[i] = rf[src][i]; snap_tgt[i] = rf[tgt][i];
      end
      exp_spr = spr_src[src];
      for (int k = 0; k < 2; k++) begin
         w0[k] = wr_cnt[k]; l0[k] = ld_cnt[k]; f0[k] = fl_cnt[k];
      end
      sw_req = 1'b1; sw_tgt = tgt;
      @(negedge clk);
      sw_req = 1'b0;
      while (busy && bcyc < 1000) begin
         if (done)
            chk(core_run == onehot_of(tgt), "R7 run enable at done", core_run, onehot_of(tgt));
         sw_req = 1'b0;
         if (bcyc == inject_at) begin
            sw_req = 1'b1; sw_tgt = ~tgt;
         end
         bcyc++;
         @(negedge clk);
      end
      sw_req = 1'b0;
      chk(bcyc == (same ? 1 : SWITCH_BUSY), "R10 busy length", bcyc, same ? 1 : SWITCH_BUSY);
      @(negedge clk);
      chk(!busy, "R9 late request ignored", busy, 0);
      chk(core_run == onehot_of(tgt) && clk_en == onehot_of(tgt),
          "R2 idle enables on target", {core_run, clk_en}, {onehot_of(tgt), onehot_of(tgt)});
      if (same) begin
         for (int i = 0; i < NSTK; i++) if (rf[tgt][i] != snap_tgt[i]) mism = 1;
         chk(!mism && wr_cnt[0] == w0[0] && wr_cnt[1] == w0[1], "R8 no writes",
             wr_cnt[tgt] - w0[tgt], 0);
         chk(ld_cnt[0] == l0[0] && ld_cnt[1] == l0[1] && fl_cnt[0] == f0[0] && fl_cnt[1] == f0[1],
             "R8 no load or flush", ld_cnt[tgt] - l0[tgt] + fl_cnt[tgt] - f0[tgt], 0);
      end else begin
         for (int i = 0; i < NSTK; i++) begin
            if (rf[tgt][i] != snap_src[i]) begin
               mism = 1;
               chk(0, "R5 register copied", rf[tgt][i], snap_src[i]);
            end
         end
         chk(!mism, "R5 all registers copied", mism, 0);
         chk(wr_cnt[tgt] - w0[tgt] == NSTK && wr_cnt[src] == w0[src], "R5 write count",
             wr_cnt[tgt] - w0[tgt], NSTK);
         chk(ld_cnt[tgt] - l0[tgt] == 1 && ld_cnt[src] == l0[src], "R3 one load on target",
             ld_cnt[tgt] - l0[tgt], 1);
         chk(spr_seen[tgt] == exp_spr, "R3 special vector", spr_seen[tgt][63:0], exp_spr[63:0]);
         chk(fl_cnt[tgt] - f0[tgt] == 1 && fl_cnt[src] == f0[src], "R6 one flush on target",
             fl_cnt[tgt] - f0[tgt], 1);
      end
      cur_core = tgt;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      for (int k = 0; k < 2; k++) begin
         wr_cnt[k] = 0; ld_cnt[k] = 0; fl_cnt[k] = 0; spr_seen[k] = '0;
         spr_src[k] = '0;
         for (int i = 0; i < NSTK; i++) rf[k][i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(!busy && !done && core_run == 2'b01 && clk_en == 2'b01 && rf_wr_en == 0
          && flush == 0 && spr_ld == 0, "R1 reset state", {busy, done, core_run, clk_en}, 6'b000101);
      rst_n = 1'b1;
      @(negedge clk);
      chk(core_run == 2'b01 && !busy, "R1 after release", core_run, 2'b01);
      // directed: change core, same core, request during done cycle
      do_switch(1'b1, -1);
      do_switch(1'b1, 0);
      do_switch(1'b0, SWITCH_BUSY - 1);
      do_switch(1'b0, -1);
      do_switch(1'b1, 5);
      // random mix
      for (int n = 0; n < 20; n++) begin
         bit t = $urandom_range(1, 0);
         int inj = $urandom_range(SWITCH_BUSY + 4, 0);
         repeat ($urandom_range(3, 0)) @(negedge clk);
         do_switch(t, inj);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule